// File: doc/BRIEF.md
# Multi-Digit Seven-Segment Leading-Zero Blanker

This block turns a packed bus of BCD digits into segment drive for a row of common-anode seven-segment digits, where a segment lights when its line is low. Each digit position has its own decode stage. A stage passes an active-low "blank me" flag down to the next less significant position. Zeros at the front of the number therefore go dark, while a zero that sits below a significant digit is still drawn.

The most significant stage always starts with blanking requested. A zero in that stage keeps the request alive for the next stage down. Any other value ends the request. A control input can force the least significant stage to show its zero, so an all-zero value appears as a single "0" and not as a fully dark display. The blank flag that leaves the last stage is brought out, so a watcher can tell when the whole display is dark. All outputs are registered, one clock after the inputs, with a synchronous active-high reset.

Top module: `ldz_display`

## Requirements
- R1: Each digit position with a value 0 to 9 that is not blanked drives its 7-bit field with segment a at bit 6 down to g at bit 0, active low: 0=0000001, 1=1001111, 2=0010010, 3=0000110, 4=1001100, 5=0100100, 6=0100000, 7=0001111, 8=0000000, 9=0000100.
- R2: A digit value of 10 to 15 turns all seven segments of its position off (1111111), and that stage passes blanking-not-requested (high) to the stage below.
- R3: The blanking request into the most significant stage is low. A stage whose digit is 0 while its incoming request is low shows all segments off and passes a low request to the stage below.
- R4: A stage whose incoming request is high, or whose digit is not 0, passes a high request to the stage below. A zero digit with a high incoming request shows the pattern 0000001, so zeros below a significant digit stay visible.
- R5: When show_zero_i is high, the incoming request of the least significant stage (bits 6:0 of the segment bus, bits 3:0 of the digit bus) is forced high, so an all-zero value shows 0000001 there and blank on every other position.
- R6: all_blank_n_o carries the request leaving the least significant stage: low exactly when every position is blanked zeros.
- R7: Outputs update at the first clock edge after the inputs change. Digit k occupies digits_i[4k+3:4k] and seg_n_o[7k+6:7k], with k=0 least significant. While rst is high at a clock edge, every segment goes off and all_blank_n_o goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| digits_i | input | 4*NUM_DIGITS | Packed BCD digits, most significant digit in the top nibble |
| show_zero_i | input | 1 | Forces the last position to show a zero for an all-zero value |
| seg_n_o | output | 7*NUM_DIGITS | Active-low segments a..g per digit, registered |
| all_blank_n_o | output | 1 | Low when the whole display is blanked, registered |

## Verification
The bench sweeps every digit combination of a three-digit build, with show_zero_i both low and high. This covers the zero-run and non-BCD corners.

Several wrong designs show up in this sweep:
- A design that blanks every zero, and not only leading ones, would darken the middle zero of 102.
- A design that forgets the chain would show leading zeros in 007.
- A design that treats a non-BCD code as zero would wrongly blank the zeros that follow it.
- A design that ignores show_zero_i would leave 000 fully dark.
- A wrong export of the last stage's flag would misreport blank displays.

The reset state and the one-cycle latency are checked at the ports.

// File: rtl/ldz_pkg.sv
package ldz_pkg;

  localparam int SEG_W = 7;
  localparam int BCD_W = 4;

  typedef logic [SEG_W-1:0] seg_t;
  typedef logic [BCD_W-1:0] bcd_t;

  localparam seg_t SEG_OFF  = 7'b1111111;
  localparam seg_t SEG_ZERO = 7'b0000001;

endpackage

// File: rtl/ldz_seg_rom.sv
module ldz_seg_rom
  import ldz_pkg::*;
(
  input  bcd_t code_i,
  output seg_t seg_n_o
);

  always_comb begin
    unique case (code_i)
      4'd0:    seg_n_o = SEG_ZERO;
      4'd1:    seg_n_o = 7'b1001111;
      4'd2:    seg_n_o = 7'b0010010;
      4'd3:    seg_n_o = 7'b0000110;
      4'd4:    seg_n_o = 7'b1001100;
      4'd5:    seg_n_o = 7'b0100100;
      4'd6:    seg_n_o = 7'b0100000;
      4'd7:    seg_n_o = 7'b0001111;
      4'd8:    seg_n_o = 7'b0000000;
      4'd9:    seg_n_o = 7'b0000100;
      default: seg_n_o = SEG_OFF;
    endcase
  end

endmodule

// File: rtl/ldz_stage.sv
module ldz_stage
  import ldz_pkg::*;
(
  input  bcd_t code_i,
  input  logic blank_req_n_i,
  output seg_t seg_n_o,
  output logic blank_req_n_o
);

  seg_t rom_seg_n;
  logic is_zero;

  ldz_seg_rom rom_i (
    .code_i  (code_i),
    .seg_n_o (rom_seg_n)
  );

  assign is_zero = (code_i == '0);

  // Blank only a zero that still has the request from above.
  always_comb begin
    if (is_zero && !blank_req_n_i) begin
      seg_n_o       = SEG_OFF;
      blank_req_n_o = 1'b0;
    end else begin
      seg_n_o       = rom_seg_n;
      blank_req_n_o = 1'b1;
    end
  end

endmodule

// File: rtl/ldz_display.sv
module ldz_display
  import ldz_pkg::*;
#(
  parameter int NUM_DIGITS = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [BCD_W*NUM_DIGITS-1:0] digits_i,
  input  logic                        show_zero_i,
  output logic [SEG_W*NUM_DIGITS-1:0] seg_n_o,
  output logic                        all_blank_n_o
);

  localparam int IN_W  = BCD_W * NUM_DIGITS;
  localparam int OUT_W = SEG_W * NUM_DIGITS;
  localparam int MSD   = NUM_DIGITS - 1;

  logic [NUM_DIGITS-1:0] req_in_n;
  logic [NUM_DIGITS-1:0] req_out_n;
  logic [OUT_W-1:0]      seg_comb_n;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_stage
    logic from_above_n;

    if (k == MSD) begin : g_top
      assign from_above_n = 1'b0;
    end else begin : g_mid
      assign from_above_n = req_out_n[k+1];
    end

    if (k == 0) begin : g_last
      assign req_in_n[k] = from_above_n | show_zero_i;
    end else begin : g_rest
      assign req_in_n[k] = from_above_n;
    end

    ldz_stage stage_i (
      .code_i        (digits_i[BCD_W*k +: BCD_W]),
      .blank_req_n_i (req_in_n[k]),
      .seg_n_o       (seg_comb_n[SEG_W*k +: SEG_W]),
      .blank_req_n_o (req_out_n[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seg_n_o       <= '1;
      all_blank_n_o <= 1'b0;
    end else begin
      seg_n_o       <= seg_comb_n;
      all_blank_n_o <= req_out_n[0];
    end
  end

  // Assertions

  p_reset_off_r7: assert property (@(posedge clk) rst |=> (&seg_n_o && !all_blank_n_o));

  p_msd_zero_blank_r3: assert property (@(posedge clk) disable iff (rst)
    (digits_i[IN_W-1 -: BCD_W] == '0 && (MSD != 0 || !show_zero_i))
      |=> (seg_n_o[OUT_W-1 -: SEG_W] == SEG_OFF));

  p_msd_digit_lit_r1: assert property (@(posedge clk) disable iff (rst)
    (digits_i[IN_W-1 -: BCD_W] inside {[4'd1:4'd9]})
      |=> (seg_n_o[OUT_W-1 -: SEG_W] != SEG_OFF));

  p_show_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (show_zero_i && digits_i == '0)
      |=> (seg_n_o[SEG_W-1:0] == SEG_ZERO && all_blank_n_o));

  p_blank_all_off_r6: assert property (@(posedge clk) disable iff (rst)
    !all_blank_n_o |-> (&seg_n_o));

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_chk
    p_invalid_off_r2: assert property (@(posedge clk) disable iff (rst)
      (digits_i[BCD_W*k +: BCD_W] > 4'd9)
        |=> (seg_n_o[SEG_W*k +: SEG_W] == SEG_OFF));
  end

endmodule

// File: tb/ldz_display_tb_top.sv
module ldz_display_tb_top;

  localparam int N = 3;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [4*N-1:0] digits = '0;
  logic           show_zero = 1'b0;
  logic [7*N-1:0] seg_n;
  logic           blank_n;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ldz_display #(.NUM_DIGITS(N)) dut_i (
    .clk           (clk),
    .rst           (rst),
    .digits_i      (digits),
    .show_zero_i   (show_zero),
    .seg_n_o       (seg_n),
    .all_blank_n_o (blank_n)
  );

  function automatic logic [6:0] pat(int d);
    case (d)
      0: pat = 7'b0000001;
      1: pat = 7'b1001111;
      2: pat = 7'b0010010;
      3: pat = 7'b0000110;
      4: pat = 7'b1001100;
      5: pat = 7'b0100100;
      6: pat = 7'b0100000;
      7: pat = 7'b0001111;
      8: pat = 7'b0000000;
      9: pat = 7'b0000100;
      default: pat = 7'b1111111;
    endcase
  endfunction

  task automatic check(string tag, logic [6:0] act, logic [6:0] exp, int v);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s input=%03h actual=%b expected=%b", tag, v, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    digits = 12'h123;
    @(posedge clk);
    #1;
    check("R7 reset segs", seg_n[6:0], 7'h7F, 0);
    check("R7 reset segs msd", seg_n[20:14], 7'h7F, 0);
    check("R7 reset blank", {6'b0, blank_n}, 7'd0, 0);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check("R7 latency", seg_n[20:14], pat(1), 12'h123);

    for (int v = 0; v < 4096; v++) begin
      for (int sz = 0; sz < 2; sz++) begin
        logic req;
        digits = v[11:0];
        show_zero = sz[0];
        @(posedge clk);
        #1;
        req = 1'b0;
        for (int k = N - 1; k >= 0; k--) begin
          int d;
          logic rin;
          d = (v >> (4 * k)) & 15;
          rin = (k == 0) ? (req | sz[0]) : req;
          if (d == 0 && !rin) begin
            check("R3 zero blanked", seg_n[7*k +: 7], 7'h7F, v);
            req = 1'b0;
          end else begin
            if (d > 9)
              check("R2 invalid off", seg_n[7*k +: 7], 7'h7F, v);
            else if (d == 0 && k == 0 && !req)
              check("R5 show zero", seg_n[7*k +: 7], pat(0), v);
            else if (d == 0)
              check("R4 inner zero", seg_n[7*k +: 7], pat(0), v);
            else
              check("R1 pattern", seg_n[7*k +: 7], pat(d), v);
            req = 1'b1;
          end
        end
        check("R6 all blank", {6'b0, blank_n}, {6'b0, req}, v);
      end
    end

    rst = 1'b1;
    digits = 12'h450;
    @(posedge clk);
    #1;
    check("R7 reset again", seg_n[13:7], 7'h7F, 12'h450);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule